// File: doc/BRIEF.md
# Butterfly Processor-to-Memory Switching Network

This block joins a set of processor-side ports to an equal number of memory-side ports. It uses several columns of two-by-two switching elements. Eight ports on each side is the default, and the port count must be a power of two. Every packet carries three things: a valid flag, the index of the memory port it is meant for, and a data payload. The network places each packet on a lane numbered 0 to n-1. In column c, each switch pairs lane p with lane p+2^c, so the two lanes differ only in bit c. The packet stays on its lane when bit c of its destination already matches bit c of its lane. Otherwise it moves to the partner lane. After the last column, the lane number equals the destination.

Every column ends in a register, so a packet that meets no contention needs one cycle per column. Sometimes two valid packets at one switch need the same output. In that case the packet on the lower-numbered lane goes ahead, and the other packet waits where it is. The column's conflict bit is raised in that cycle. A waiting packet blocks any packet behind it that wants its slot. At the processor side this shows up as a deasserted ready. The memory side never stalls.

Top module: `bfly_net`

## Requirements
- R1: A packet that meets no contention is accepted at a processor port while in_ready_o is high. Exactly STAGES = log2(n) cycles later, it shows on out_valid_o and out_data_o of the memory port given by its destination, for exactly one cycle, with its payload unchanged.
- R2: In column c, a packet on lane p keeps lane p when destination bit c equals bit c of p, and otherwise moves to lane p XOR 2^c. Each delivered packet therefore leaves on the memory port whose index equals its destination, and out_dst_o repeats that destination.
- R3: Two valid packets at one switch may need the same output. The packet on the lower-numbered lane advances, and the packet on the higher-numbered lane is not granted in that cycle. At column 0, this means in_ready_o is low for the higher-numbered processor port.
- R4: conflict_o[c] is high in a cycle only when some column-c switch has two valid packets with the same destination bit c. It is low in every other cycle, including under any pattern with destination = source XOR k.
- R5: A packet whose valid flag is low never causes a conflict and never blocks another packet, whatever its destination bits hold.
- R6: A packet that is not granted keeps its position and its contents, and it advances in a later cycle. A slot that is still occupied refuses any new packet that wants it, and this back-pressure reaches the processor ports as in_ready_o low.
- R7: While rst_ni is low, every out_valid_o bit is 0, and in_ready_o is 1 on every port with no valid input.
- R8: in_ready_o[p] is 1 exactly when port p has no valid packet or its packet is accepted in the current cycle.
- R9: Every accepted packet is delivered exactly once. A full load of n packets per cycle with destinations source XOR k is accepted on every cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_PORTS | A packet is present on each processor port |
| in_dst_i | input | N_PORTS x STAGES | Destination memory index for each processor port |
| in_data_i | input | N_PORTS x DATA_W | Payload for each processor port |
| in_ready_o | output | N_PORTS | The packet on the port is taken in this cycle (or the port is idle) |
| out_valid_o | output | N_PORTS | A packet is delivered on each memory port |
| out_dst_o | output | N_PORTS x STAGES | Destination carried by the delivered packet |
| out_data_o | output | N_PORTS x DATA_W | Payload of the delivered packet |
| conflict_o | output | STAGES | Per column: two packets at one switch contend for the same output |

## Verification
Ready and conflict are combinational functions of the inputs and the column registers. For that reason they are checked 1 ns after new inputs are driven and before the next rising edge. A packet driven while the bench's cycle count is c, and accepted at once, is due on the memory port when that count reaches c+STAGES. Each cycle that a packet waits adds one cycle to that figure. The bench derives the delays for the two contention scenarios from the lane rules alone. The reference model is a queue of (cycle, port, payload) entries. At every falling edge, each memory port is compared against that queue, so an early, late, duplicated or missing delivery each fails in the exact cycle where it occurs.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  typedef enum logic {
    ROUTE_STRAIGHT = 1'b0,
    ROUTE_CROSS    = 1'b1
  } route_e;

  function automatic route_e route_of(logic lane_bit, logic dst_bit);
    return (lane_bit == dst_bit) ? ROUTE_STRAIGHT : ROUTE_CROSS;
  endfunction

endpackage

// File: rtl/bfly_column.sv
module bfly_column
  import bfly_pkg::*;
#(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned DST_W   = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned COL     = 0
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [N_PORTS-1:0]                 in_valid_i,
  input  logic [N_PORTS-1:0][DST_W-1:0]      in_dst_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0]     in_data_i,
  output logic [N_PORTS-1:0]                 grant_o,
  input  logic [N_PORTS-1:0]                 drain_i,
  output logic [N_PORTS-1:0]                 out_valid_o,
  output logic [N_PORTS-1:0][DST_W-1:0]      out_dst_o,
  output logic [N_PORTS-1:0][DATA_W-1:0]     out_data_o,
  output logic                               conflict_o
);

  localparam int unsigned STRIDE = 32'd1 << COL;

  logic [N_PORTS-1:0] free_w;
  logic [N_PORTS-1:0] cross_w;
  logic [N_PORTS-1:0] clash_w;
  logic [N_PORTS-1:0] grant_w;

  for (genvar x = 0; x < N_PORTS; x++) begin : g_lane
    localparam int unsigned PART = x ^ STRIDE;
    // upper lane of the pair loses on contention
    localparam logic        UPPER = ((x >> COL) & 1) != 0;
    localparam logic [DST_W-1:0] XPOS = DST_W'(x);

    logic              v_q;
    logic [DST_W-1:0]  d_q;
    logic [DATA_W-1:0] dat_q;
    logic              take_self, take_part;

    assign cross_w[x] = (route_of(UPPER, in_dst_i[x][COL]) == ROUTE_CROSS);
    assign clash_w[x] = in_valid_i[x] & in_valid_i[PART]
                      & (in_dst_i[x][COL] == in_dst_i[PART][COL]);
    assign free_w[x]  = ~v_q | drain_i[x];
    assign grant_w[x] = in_valid_i[x] & ~(clash_w[x] & UPPER)
                      & (cross_w[x] ? free_w[PART] : free_w[x]);

    assign take_self = grant_w[x] & ~cross_w[x];
    assign take_part = grant_w[PART] & cross_w[PART];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q   <= 1'b0;
        d_q   <= '0;
        dat_q <= '0;
      end else if (free_w[x]) begin
        v_q   <= take_self | take_part;
        d_q   <= take_part ? in_dst_i[PART]  : in_dst_i[x];
        dat_q <= take_part ? in_data_i[PART] : in_data_i[x];
      end
    end

    assign out_valid_o[x] = v_q;
    assign out_dst_o[x]   = d_q;
    assign out_data_o[x]  = dat_q;

    p_invalid_no_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i[x] |-> !grant_o[x]);

    p_hold_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[x] && !drain_i[x]) |=>
        (out_valid_o[x] && $stable(out_dst_o[x]) && $stable(out_data_o[x])));

    p_lane_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[x] |-> (out_dst_o[x][COL:0] == XPOS[COL:0]));

    if (UPPER) begin : g_upper
      p_lower_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i[x] && in_valid_i[PART] &&
         in_dst_i[x][COL] == in_dst_i[PART][COL]) |-> !grant_o[x]);
    end
  end

  assign grant_o    = grant_w;
  assign conflict_o = |clash_w;

endmodule

// File: rtl/bfly_net.sv
module bfly_net #(
  parameter  int unsigned N_PORTS = 8,
  parameter  int unsigned DATA_W  = 8,
  localparam int unsigned STAGES  = $clog2(N_PORTS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_PORTS-1:0]              in_valid_i,
  input  logic [N_PORTS-1:0][STAGES-1:0]  in_dst_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0]  in_data_i,
  output logic [N_PORTS-1:0]              in_ready_o,
  output logic [N_PORTS-1:0]              out_valid_o,
  output logic [N_PORTS-1:0][STAGES-1:0]  out_dst_o,
  output logic [N_PORTS-1:0][DATA_W-1:0]  out_data_o,
  output logic [STAGES-1:0]               conflict_o
);

  logic [N_PORTS-1:0]             vld_w  [STAGES+1];
  logic [N_PORTS-1:0][STAGES-1:0] dst_w  [STAGES+1];
  logic [N_PORTS-1:0][DATA_W-1:0] dat_w  [STAGES+1];
  logic [N_PORTS-1:0]             gnt_w  [STAGES];
  logic [N_PORTS-1:0]             drn_w  [STAGES];

  assign vld_w[0] = in_valid_i;
  assign dst_w[0] = in_dst_i;
  assign dat_w[0] = in_data_i;

  for (genvar c = 0; c < STAGES; c++) begin : g_col
    // last column always empties into the memory ports
    if (c == STAGES - 1) begin : g_last
      assign drn_w[c] = '1;
    end else begin : g_mid
      assign drn_w[c] = gnt_w[c+1];
    end

    bfly_column #(
      .N_PORTS (N_PORTS),
      .DST_W   (STAGES),
      .DATA_W  (DATA_W),
      .COL     (c)
    ) u_col (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .in_valid_i  (vld_w[c]),
      .in_dst_i    (dst_w[c]),
      .in_data_i   (dat_w[c]),
      .grant_o     (gnt_w[c]),
      .drain_i     (drn_w[c]),
      .out_valid_o (vld_w[c+1]),
      .out_dst_o   (dst_w[c+1]),
      .out_data_o  (dat_w[c+1]),
      .conflict_o  (conflict_o[c])
    );
  end

  assign in_ready_o  = ~in_valid_i | gnt_w[0];
  assign out_valid_o = vld_w[STAGES];
  assign out_dst_o   = dst_w[STAGES];
  assign out_data_o  = dat_w[STAGES];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_chk
    p_delivery_port_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[p] |-> (out_dst_o[p] == STAGES'(p)));
  end

  p_reset_idle_r7: assert property (@(posedge clk_i)
    !rst_ni |-> (out_valid_o == '0));

endmodule

// File: tb/bfly_net_tb.sv
module bfly_net_tb;

  localparam int N  = 8;
  localparam int S  = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]         in_valid;
  logic [N-1:0][S-1:0]  in_dst;
  logic [N-1:0][DW-1:0] in_data;
  logic [N-1:0]         in_ready;
  logic [N-1:0]         out_valid;
  logic [N-1:0][S-1:0]  out_dst;
  logic [N-1:0][DW-1:0] out_data;
  logic [S-1:0]         conflict;

  always #10 clk = ~clk;

  bfly_net #(.N_PORTS(N), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_dst_i(in_dst), .in_data_i(in_data),
    .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_dst_o(out_dst), .out_data_o(out_data),
    .conflict_o(conflict)
  );

  typedef struct { int cyc; int port; int data; } exp_t;
  exp_t exp_q[$];

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic expect_pkt(int due, int port, int data);
    exp_t e;
    e.cyc = due; e.port = port; e.data = data;
    exp_q.push_back(e);
  endtask

  // one clock: advance, then compare every memory port with the queue
  task automatic step();
    exp_t keep[$];
    @(posedge clk);
    cyc++;
    @(negedge clk);
    for (int q = 0; q < N; q++) begin
      bit ev;
      int ed;
      ev = 1'b0;
      ed = 0;
      foreach (exp_q[i]) if (exp_q[i].cyc == cyc && exp_q[i].port == q) begin
        ev = 1'b1;
        ed = exp_q[i].data;
      end
      check(out_valid[q] == ev, "R9", $sformatf("valid port %0d", q), int'(out_valid[q]), int'(ev));
      if (ev && out_valid[q]) begin
        check(out_data[q] == DW'(ed), "R1", $sformatf("data port %0d", q), int'(out_data[q]), ed);
        check(out_dst[q] == S'(q), "R2", $sformatf("dst port %0d", q), int'(out_dst[q]), q);
      end
    end
    foreach (exp_q[i]) if (exp_q[i].cyc > cyc) keep.push_back(exp_q[i]);
    exp_q = keep;
  endtask

  task automatic clear_in();
    in_valid = '0;
    in_dst   = '0;
    in_data  = '0;
  endtask

  task automatic drive(int p, int dst, int data);
    in_valid[p] = 1'b1;
    in_dst[p]   = S'(dst);
    in_data[p]  = DW'(data);
  endtask

  task automatic flush(int n);
    clear_in();
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin
    int c;
    clear_in();
    // R7: reset state
    for (int i = 0; i < 3; i++) begin
      step();
      check(out_valid == '0, "R7", "out_valid in reset", int'(out_valid), 0);
      check(in_ready == '1, "R7", "in_ready in reset", int'(in_ready), 255);
    end
    rst_n = 1'b1;
    step();

    // R9/R1/R4/R8: full load, dst = src xor k, one wave per cycle
    for (int k = 0; k < N; k++) begin
      for (int p = 0; p < N; p++) drive(p, p ^ k, k * 16 + p);
      #1;
      check(in_ready == '1, "R8", $sformatf("ready full load k=%0d", k), int'(in_ready), 255);
      check(conflict == '0, "R4", $sformatf("conflict full load k=%0d", k), int'(conflict), 0);
      for (int p = 0; p < N; p++) expect_pkt(cyc + S, p ^ k, k * 16 + p);
      step();
    end
    flush(S + 1);

    // R3/R4: contention in column 0; lane 0 wins, lane 1 waits one cycle
    c = cyc;
    drive(0, 0, 8'hA1);
    drive(1, 2, 8'hB2);
    #1;
    check(conflict == 3'b001, "R4", "column 0 conflict", int'(conflict), 1);
    check(in_ready[0] == 1'b1, "R3", "lower lane ready", int'(in_ready[0]), 1);
    check(in_ready[1] == 1'b0, "R3", "upper lane held", int'(in_ready[1]), 0);
    expect_pkt(c + S, 0, 8'hA1);
    step();
    in_valid[0] = 1'b0;
    #1;
    check(in_ready[1] == 1'b1, "R6", "held lane accepted later", int'(in_ready[1]), 1);
    check(conflict == 3'b000, "R4", "no conflict on retry", int'(conflict), 0);
    expect_pkt(c + S + 1, 2, 8'hB2);
    step();
    flush(S + 1);

    // R3/R4/R6/R8: contention in column 1 blocks a follower at port 3
    c = cyc;
    drive(0, 0, 8'hC0);
    drive(2, 4, 8'hC4);
    #1;
    check(conflict == 3'b000, "R4", "no column 0 conflict", int'(conflict), 0);
    check(in_ready[0] && in_ready[2], "R8", "both accepted", int'(in_ready), 255);
    expect_pkt(c + 3, 0, 8'hC0);
    expect_pkt(c + 4, 4, 8'hC4);
    step();
    clear_in();
    drive(3, 6, 8'hC6);
    #1;
    check(conflict == 3'b010, "R4", "column 1 conflict", int'(conflict), 2);
    check(in_ready[3] == 1'b0, "R6", "follower blocked by held slot", int'(in_ready[3]), 0);
    step();
    #1;
    check(conflict == 3'b000, "R4", "conflict cleared", int'(conflict), 0);
    check(in_ready[3] == 1'b1, "R6", "follower accepted after drain", int'(in_ready[3]), 1);
    expect_pkt(c + 5, 6, 8'hC6);
    step();
    flush(S + 2);

    // R5/R2: invalid partner with a clashing destination; plus a lone packet
    c = cyc;
    drive(0, 0, 8'hE0);
    in_dst[1]  = S'(0);
    in_data[1] = 8'hEE;
    drive(5, 3, 8'h53);
    #1;
    check(conflict == 3'b000, "R5", "invalid slot causes no conflict", int'(conflict), 0);
    check(in_ready == '1, "R5", "all ports ready", int'(in_ready), 255);
    expect_pkt(c + S, 0, 8'hE0);
    expect_pkt(c + S, 3, 8'h53);
    step();
    flush(S + 1);

    check(exp_q.size() == 0, "R9", "undelivered packets", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule